// File: doc/BRIEF.md
# PS/2 Host Controller Register Interface

This block is the host-facing register file and command sequencer of a two-channel PS/2 controller, with one keyboard channel and one mouse channel. A byte-wide host bus reaches two addresses: a data port and a command/status port. Inside there is a status byte, a configuration byte, one output data register shared by both channels, and a pending-command state. The pending-command state lets a two-phase command steer the next data-port write.

On the device side, each channel has a simple byte handshake. The channel raises an "available" flag with a byte. The block answers with a one-cycle pull strobe when it takes that byte. For host-to-device bytes the block drives a one-cycle push strobe with the byte. Whenever the output register is empty, it fills itself from the channels, and the keyboard wins over the mouse. A host read of the data port frees the register and refills it in the same cycle. Each load of the output register may raise a one-cycle interrupt pulse for its channel, gated by the enable bits of the configuration byte. Serial line signalling is outside this block. So are password, self-test, gate and controller-memory commands, which only raise an error pulse.

Top module: `ps2_host_regs`

## Requirements
- R1: After reset the status byte reads 0x1C (bits 2, 3 and 4 set) and the configuration byte holds 0x45 (bits 0, 2 and 6 set).
- R2: A read with `bus_cmd`=1 returns the status byte: bit 0 output-full, bit 2 self-test flag, bit 3 last-write-was-command, bit 4 unlocked (always 1), bit 5 mouse-output-full, other bits 0. A read with `bus_cmd`=0 returns the output register.
- R3: Any load of the output register sets output-full and sets mouse-output-full only for a mouse-sourced byte. In the next cycle, `irq_kbd` pulses for one cycle if the byte is keyboard-sourced and configuration bit 0 is set. `irq_mse` pulses likewise for a mouse-sourced byte when configuration bit 1 is set.
- R4: A data-port read clears output-full and mouse-output-full. In the same cycle the block pulls a byte from the keyboard channel if it has one, otherwise from the mouse channel.
- R5: A full output register is never overwritten by channel data. A pull strobe occurs only when the register is empty or is being read in that cycle.
- R6: A command-port write sets status bit 3. A data-port write clears it.
- R7: With no command pending, a data-port write pulses `kbd_push` with the byte. After command 0xD4, the next data-port write pulses `mse_push` instead.
- R8: After command 0x60, the next data-port write loads the configuration byte and copies its bit 2 into status bit 2.
- R9: After command 0xD2 (or 0xD3), the next data-port write loads the output register as a keyboard-sourced (or mouse-sourced) byte.
- R10: Every data-port write returns the pending command to none.
- R11: Command 0x20 loads the configuration byte into the output register as keyboard data. Commands 0xA7 and 0xA8 set and clear configuration bit 5. Commands 0xAD and 0xAE set and clear configuration bit 4.
- R12: `cmd_err` pulses one cycle after a command write whose code is unsupported. The unsupported codes are 0x21–0x3F, 0x61–0x7F, 0xF0–0xFE, 0xA4–0xA6, 0xA9–0xAC, 0xC0–0xC2, 0xD0, 0xDD, 0xDF and 0xE0. `cmd_err` also pulses one cycle after a data write following 0xD1 whose bit 0 is 0. No other code flags an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Host access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_cmd | input | 1 | 1 = command/status port, 0 = data port |
| bus_wdata | input | 8 | Host write byte |
| bus_rdata | output | 8 | Host read byte (combinational) |
| kbd_avail | input | 1 | Keyboard channel holds a byte |
| kbd_rx_byte | input | 8 | Keyboard byte offered |
| kbd_pull | output | 1 | Keyboard byte taken this cycle |
| kbd_push | output | 1 | Byte sent to keyboard this cycle |
| kbd_tx_byte | output | 8 | Byte sent to keyboard |
| mse_avail | input | 1 | Mouse channel holds a byte |
| mse_rx_byte | input | 8 | Mouse byte offered |
| mse_pull | output | 1 | Mouse byte taken this cycle |
| mse_push | output | 1 | Byte sent to mouse this cycle |
| mse_tx_byte | output | 8 | Byte sent to mouse |
| irq_kbd | output | 1 | Keyboard interrupt pulse |
| irq_mse | output | 1 | Mouse interrupt pulse |
| cmd_err | output | 1 | Unsupported command or bad output-port byte |

## Verification
The assertions assume that a channel keeps its available flag and byte steady until it sees its pull strobe. They also assume the host makes at most one access per cycle. The stimulus meets both assumptions: the bench raises a channel flag only between accesses, lowers it only after the cycle of the pull, and drives each access for exactly one cycle. The command sweep covers every code except the ones that open a data phase or load the output register, so no sweep step can leave a pending command behind.

// File: rtl/ps2c_pkg.sv
package ps2c_pkg;

    localparam int BYTE_W = 8;

    // command codes
    localparam logic [7:0] OP_CFG_RD   = 8'h20;
    localparam logic [7:0] OP_CFG_WR   = 8'h60;
    localparam logic [7:0] OP_MSE_OFF  = 8'hA7;
    localparam logic [7:0] OP_MSE_ON   = 8'hA8;
    localparam logic [7:0] OP_KBD_OFF  = 8'hAD;
    localparam logic [7:0] OP_KBD_ON   = 8'hAE;
    localparam logic [7:0] OP_OPORT_WR = 8'hD1;
    localparam logic [7:0] OP_KOB_WR   = 8'hD2;
    localparam logic [7:0] OP_MOB_WR   = 8'hD3;
    localparam logic [7:0] OP_TO_MSE   = 8'hD4;
    localparam logic [7:0] OP_PULSE_LO = 8'hF0;

    // configuration bit positions
    localparam int CFG_KIRQ   = 0;
    localparam int CFG_MIRQ   = 1;
    localparam int CFG_SYS    = 2;
    localparam int CFG_KOFF   = 4;
    localparam int CFG_MOFF   = 5;
    localparam int CFG_XLAT   = 6;

    localparam logic [7:0] CFG_RESET = 8'h45;

    typedef enum logic [2:0] {
        PEND_NONE,
        PEND_CFG,
        PEND_OPORT,
        PEND_KOB,
        PEND_MOB,
        PEND_MSE
    } pend_e;

    typedef struct packed {
        logic               valid;
        logic               mouse;
        logic [BYTE_W-1:0]  data;
    } load_t;

    typedef struct packed {
        logic   cfg_rd;
        logic   arm;
        pend_e  arm_to;
        logic   moff_set;
        logic   moff_clr;
        logic   koff_set;
        logic   koff_clr;
        logic   unsup;
    } cmd_dec_t;

    function automatic logic in_span(input logic [7:0] c, input int lo, input int hi);
        return (int'(c) >= lo) && (int'(c) <= hi);
    endfunction

    function automatic logic legacy_unsup(input logic [7:0] c);
        return in_span(c, 8'hA4, 8'hA6) || in_span(c, 8'hA9, 8'hAC) ||
               in_span(c, 8'hC0, 8'hC2) || (c == 8'hD0) || (c == 8'hDD) ||
               (c == 8'hDF) || (c == 8'hE0) || (c == 8'hFE);
    endfunction

    function automatic logic [7:0] pack_status(input logic obf, input logic mobf,
                                               input logic cmd_last, input logic sys);
        return {2'b00, mobf, 1'b1, cmd_last, sys, 1'b0, obf};
    endfunction

endpackage

// File: rtl/ps2c_cmd_decode.sv
module ps2c_cmd_decode
    import ps2c_pkg::*;
#(
    parameter int RAM_WINDOW  = 32,
    parameter int PULSE_COUNT = 14
) (
    input  logic [7:0] code,
    output cmd_dec_t   dec
);
    localparam int RD_LO = int'(OP_CFG_RD) + 1;
    localparam int RD_HI = int'(OP_CFG_RD) + RAM_WINDOW - 1;
    localparam int WR_LO = int'(OP_CFG_WR) + 1;
    localparam int WR_HI = int'(OP_CFG_WR) + RAM_WINDOW - 1;
    localparam int PL_LO = int'(OP_PULSE_LO);
    localparam int PL_HI = int'(OP_PULSE_LO) + PULSE_COUNT - 1;

    always_comb begin
        dec          = '0;
        dec.arm_to   = PEND_NONE;
        dec.unsup    = in_span(code, RD_LO, RD_HI) || in_span(code, WR_LO, WR_HI) ||
                       in_span(code, PL_LO, PL_HI) || legacy_unsup(code);
        unique case (code)
            OP_CFG_RD:   dec.cfg_rd   = 1'b1;
            OP_CFG_WR:   begin dec.arm = 1'b1; dec.arm_to = PEND_CFG;   end
            OP_OPORT_WR: begin dec.arm = 1'b1; dec.arm_to = PEND_OPORT; end
            OP_KOB_WR:   begin dec.arm = 1'b1; dec.arm_to = PEND_KOB;   end
            OP_MOB_WR:   begin dec.arm = 1'b1; dec.arm_to = PEND_MOB;   end
            OP_TO_MSE:   begin dec.arm = 1'b1; dec.arm_to = PEND_MSE;   end
            OP_MSE_OFF:  dec.moff_set = 1'b1;
            OP_MSE_ON:   dec.moff_clr = 1'b1;
            OP_KBD_OFF:  dec.koff_set = 1'b1;
            OP_KBD_ON:   dec.koff_clr = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ps2c_ctrl_state.sv
module ps2c_ctrl_state
    import ps2c_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_wr,
    input  logic        data_wr,
    input  logic [7:0]  wdata,
    input  cmd_dec_t    dec,
    output logic [7:0]  cfg,
    output pend_e       pend,
    output logic        cmd_last,
    output logic        sys_flag,
    output logic        err
);
    logic bad_oport;
    assign bad_oport = data_wr && (pend == PEND_OPORT) && !wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg      <= CFG_RESET;
            pend     <= PEND_NONE;
            cmd_last <= 1'b1;
            sys_flag <= 1'b1;
            err      <= 1'b0;
        end else begin
            err <= (cmd_wr && dec.unsup) || bad_oport;
            if (cmd_wr) begin
                cmd_last <= 1'b1;
                if (dec.arm)      pend           <= dec.arm_to;
                if (dec.moff_set) cfg[CFG_MOFF]  <= 1'b1;
                if (dec.moff_clr) cfg[CFG_MOFF]  <= 1'b0;
                if (dec.koff_set) cfg[CFG_KOFF]  <= 1'b1;
                if (dec.koff_clr) cfg[CFG_KOFF]  <= 1'b0;
            end else if (data_wr) begin
                cmd_last <= 1'b0;
                pend     <= PEND_NONE;
                if (pend == PEND_CFG) begin
                    cfg      <= wdata;
                    sys_flag <= wdata[CFG_SYS];
                end
            end
        end
    end
endmodule

// File: rtl/ps2c_outbuf.sv
module ps2c_outbuf
    import ps2c_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  load_t             host_load,
    input  logic              data_rd,
    input  logic [NUM_CH-1:0] avail,
    input  logic [7:0]        rx_byte [NUM_CH],
    input  logic [NUM_CH-1:0] irq_en,
    output logic [NUM_CH-1:0] pull,
    output logic [NUM_CH-1:0] irq,
    output logic              obf,
    output logic              mobf,
    output logic [7:0]        dout
);
    logic  room;
    load_t nxt;

    assign room = !host_load.valid && (!obf || data_rd);

    // channel 0 (keyboard) outranks channel 1 (mouse)
    genvar g;
    generate
        for (g = 0; g < NUM_CH; g++) begin : g_pull
            if (g == 0) begin : g_first
                assign pull[g] = room && avail[g];
            end else begin : g_rest
                assign pull[g] = room && avail[g] && !(|avail[g-1:0]);
            end
        end
    endgenerate

    always_comb begin
        nxt = host_load;
        if (pull[0])      nxt = '{valid: 1'b1, mouse: 1'b0, data: rx_byte[0]};
        else if (pull[1]) nxt = '{valid: 1'b1, mouse: 1'b1, data: rx_byte[1]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            obf  <= 1'b0;
            mobf <= 1'b0;
            dout <= '0;
            irq  <= '0;
        end else begin
            irq <= '0;
            if (nxt.valid) begin
                obf  <= 1'b1;
                mobf <= nxt.mouse;
                dout <= nxt.data;
                irq  <= {nxt.mouse && irq_en[1], !nxt.mouse && irq_en[0]};
            end else if (data_rd) begin
                obf  <= 1'b0;
                mobf <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/ps2_host_regs.sv
module ps2_host_regs
    import ps2c_pkg::*;
#(
    parameter int RAM_WINDOW  = 32,
    parameter int PULSE_COUNT = 14
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_en,
    input  logic       bus_we,
    input  logic       bus_cmd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       kbd_avail,
    input  logic [7:0] kbd_rx_byte,
    output logic       kbd_pull,
    output logic       kbd_push,
    output logic [7:0] kbd_tx_byte,
    input  logic       mse_avail,
    input  logic [7:0] mse_rx_byte,
    output logic       mse_pull,
    output logic       mse_push,
    output logic [7:0] mse_tx_byte,
    output logic       irq_kbd,
    output logic       irq_mse,
    output logic       cmd_err
);
    logic       cmd_wr, data_wr, data_rd;
    cmd_dec_t   dec;
    logic [7:0] cfg;
    pend_e      pend;
    logic       cmd_last, sys_flag;
    load_t      host_load;
    logic       obf, mobf;
    logic [7:0] dout;
    logic [1:0] pull, irq;
    logic [7:0] rx_bytes [2];

    assign cmd_wr  = bus_en && bus_we && bus_cmd;
    assign data_wr = bus_en && bus_we && !bus_cmd;
    assign data_rd = bus_en && !bus_we && !bus_cmd;

    ps2c_cmd_decode #(
        .RAM_WINDOW (RAM_WINDOW),
        .PULSE_COUNT(PULSE_COUNT)
    ) u_dec (
        .code(bus_wdata),
        .dec (dec)
    );

    ps2c_ctrl_state u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .cmd_wr  (cmd_wr),
        .data_wr (data_wr),
        .wdata   (bus_wdata),
        .dec     (dec),
        .cfg     (cfg),
        .pend    (pend),
        .cmd_last(cmd_last),
        .sys_flag(sys_flag),
        .err     (cmd_err)
    );

    always_comb begin
        host_load = '0;
        if (cmd_wr && dec.cfg_rd)
            host_load = '{valid: 1'b1, mouse: 1'b0, data: cfg};
        else if (data_wr && pend == PEND_KOB)
            host_load = '{valid: 1'b1, mouse: 1'b0, data: bus_wdata};
        else if (data_wr && pend == PEND_MOB)
            host_load = '{valid: 1'b1, mouse: 1'b1, data: bus_wdata};
    end

    assign rx_bytes[0] = kbd_rx_byte;
    assign rx_bytes[1] = mse_rx_byte;

    ps2c_outbuf #(.NUM_CH(2)) u_obuf (
        .clk      (clk),
        .rst      (rst),
        .host_load(host_load),
        .data_rd  (data_rd),
        .avail    ({mse_avail, kbd_avail}),
        .rx_byte  (rx_bytes),
        .irq_en   ({cfg[CFG_MIRQ], cfg[CFG_KIRQ]}),
        .pull     (pull),
        .irq      (irq),
        .obf      (obf),
        .mobf     (mobf),
        .dout     (dout)
    );

    assign kbd_pull    = pull[0];
    assign mse_pull    = pull[1];
    assign irq_kbd     = irq[0];
    assign irq_mse     = irq[1];
    assign kbd_push    = data_wr && (pend == PEND_NONE);
    assign mse_push    = data_wr && (pend == PEND_MSE);
    assign kbd_tx_byte = bus_wdata;
    assign mse_tx_byte = bus_wdata;
    assign bus_rdata   = bus_cmd ? pack_status(obf, mobf, cmd_last, sys_flag) : dout;
endmodule

// File: rtl/ps2c_chk.sv
module ps2c_chk
    import ps2c_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  bus_en,
    input logic  bus_we,
    input logic  bus_cmd,
    input logic  kbd_avail,
    input logic  kbd_pull,
    input logic  mse_pull,
    input logic  kbd_push,
    input logic  irq_kbd,
    input logic  irq_mse,
    input logic  obf,
    input logic  mobf,
    input logic  cmd_last,
    input pend_e pend
);
    logic rd_data, wr_data, wr_cmd;
    assign rd_data = bus_en && !bus_we && !bus_cmd;
    assign wr_data = bus_en && bus_we && !bus_cmd;
    assign wr_cmd  = bus_en && bus_we && bus_cmd;

    // R5
    no_full_overwrite_chk: assert property (@(posedge clk) disable iff (rst)
        (kbd_pull || mse_pull) |-> (!obf || rd_data));
    // R4
    pull_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(kbd_pull && mse_pull));
    // R4
    kbd_first_chk: assert property (@(posedge clk) disable iff (rst)
        mse_pull |-> !kbd_avail);
    // R3
    irq_kbd_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_kbd |-> (obf && !mobf));
    // R3
    irq_mse_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq_mse |-> (obf && mobf));
    // R2
    mobf_implies_obf_chk: assert property (@(posedge clk) disable iff (rst)
        mobf |-> obf);
    // R6
    cmd_last_set_chk: assert property (@(posedge clk) disable iff (rst)
        wr_cmd |=> cmd_last);
    // R6
    cmd_last_clr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> !cmd_last);
    // R10
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        wr_data |=> (pend == PEND_NONE));
    // R7
    kbd_push_src_chk: assert property (@(posedge clk) disable iff (rst)
        kbd_push |-> wr_data);
endmodule

bind ps2_host_regs ps2c_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_en   (bus_en),
    .bus_we   (bus_we),
    .bus_cmd  (bus_cmd),
    .kbd_avail(kbd_avail),
    .kbd_pull (kbd_pull),
    .mse_pull (mse_pull),
    .kbd_push (kbd_push),
    .irq_kbd  (irq_kbd),
    .irq_mse  (irq_mse),
    .obf      (obf),
    .mobf     (mobf),
    .cmd_last (cmd_last),
    .pend     (pend)
);

// File: tb/ps2_host_regs_tb.sv
module ps2_host_regs_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_en = 1'b0, bus_we = 1'b0, bus_cmd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       kbd_avail = 1'b0, mse_avail = 1'b0;
    logic [7:0] kbd_rx_byte = '0, mse_rx_byte = '0;
    logic       kbd_pull, kbd_push, mse_pull, mse_push;
    logic [7:0] kbd_tx_byte, mse_tx_byte;
    logic       irq_kbd, irq_mse, cmd_err;

    int total = 0;
    int bad   = 0;

    // snapshots: combinational before the edge, registered after it
    logic [7:0] s_rd, s_ktx, s_mtx;
    logic       s_kpush, s_mpush, s_kpull, s_mpull, s_irqk, s_irqm, s_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    ps2_host_regs u_dut (
        .clk(clk), .rst(rst),
        .bus_en(bus_en), .bus_we(bus_we), .bus_cmd(bus_cmd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .kbd_avail(kbd_avail), .kbd_rx_byte(kbd_rx_byte),
        .kbd_pull(kbd_pull), .kbd_push(kbd_push), .kbd_tx_byte(kbd_tx_byte),
        .mse_avail(mse_avail), .mse_rx_byte(mse_rx_byte),
        .mse_pull(mse_pull), .mse_push(mse_push), .mse_tx_byte(mse_tx_byte),
        .irq_kbd(irq_kbd), .irq_mse(irq_mse), .cmd_err(cmd_err)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic access(input logic en, input logic we, input logic cmd, input logic [7:0] d);
        @(negedge clk);
        bus_en = en; bus_we = we; bus_cmd = cmd; bus_wdata = d;
        #1;
        s_rd = bus_rdata; s_kpush = kbd_push; s_mpush = mse_push;
        s_ktx = kbd_tx_byte; s_mtx = mse_tx_byte;
        s_kpull = kbd_pull; s_mpull = mse_pull;
        @(posedge clk);
        #1;
        s_irqk = irq_kbd; s_irqm = irq_mse; s_err = cmd_err;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr_cmd(input logic [7:0] c);  access(1'b1, 1'b1, 1'b1, c); endtask
    task automatic wr_dat(input logic [7:0] d);  access(1'b1, 1'b1, 1'b0, d); endtask
    task automatic rd_stat(input string tag, input int exp);
        access(1'b1, 1'b0, 1'b1, 8'h00); chk(tag, int'(s_rd), exp);
    endtask
    task automatic rd_dat(input string tag, input int exp);
        access(1'b1, 1'b0, 1'b0, 8'h00); chk(tag, int'(s_rd), exp);
    endtask
    task automatic idle();  access(1'b0, 1'b0, 1'b0, 8'h00); endtask

    function automatic bit exp_unsup(input int c);
        return (c > 'h20 && c < 'h40) || (c > 'h60 && c < 'h80) ||
               (c >= 'hF0 && c <= 'hFE) || (c >= 'hA4 && c <= 'hA6) ||
               (c >= 'hA9 && c <= 'hAC) || (c >= 'hC0 && c <= 'hC2) ||
               c == 'hD0 || c == 'hDD || c == 'hDF || c == 'hE0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset status and configuration
        rd_stat("R1 reset status", 'h1C);
        wr_cmd(8'h20);
        chk("R11 cfg read irq", int'(s_irqk), 1);
        rd_stat("R2 status full", 'h1D);
        rd_dat("R1 reset cfg", 'h45);
        rd_stat("R4 status after read", 'h1C);

        // R8 config write copies system flag
        wr_cmd(8'h60);
        wr_dat(8'h03);
        rd_stat("R8 status bit2 copy / R6 cleared", 'h10);
        wr_cmd(8'h20);
        rd_dat("R8 cfg value", 'h03);

        // R9 / R3 host-forced loads with both irq enables set
        wr_cmd(8'hD2); wr_dat(8'hAB);
        chk("R3 kbd irq", int'(s_irqk), 1);
        chk("R3 no mse irq", int'(s_irqm), 0);
        rd_stat("R9 kbd-sourced status", 'h11);
        rd_dat("R9 kbd byte", 'hAB);
        wr_cmd(8'hD3); wr_dat(8'h5A);
        chk("R3 mse irq", int'(s_irqm), 1);
        chk("R3 no kbd irq", int'(s_irqk), 0);
        rd_stat("R9 mse-sourced status", 'h31);
        rd_dat("R9 mse byte", 'h5A);

        // R3 irq gating off
        wr_cmd(8'h60); wr_dat(8'h44);
        rd_stat("R8 system flag back", 'h14);
        wr_cmd(8'hD2); wr_dat(8'h77);
        chk("R3 kbd irq gated", int'(s_irqk), 0);
        rd_dat("R9 byte 77", 'h77);
        wr_cmd(8'hD3); wr_dat(8'h78);
        chk("R3 mse irq gated", int'(s_irqm), 0);
        rd_dat("R9 byte 78", 'h78);
        wr_cmd(8'h60); wr_dat(8'h47);

        // R7 / R10 routing
        wr_dat(8'h9E);
        chk("R7 kbd push", int'(s_kpush), 1);
        chk("R7 kbd byte", int'(s_ktx), 'h9E);
        chk("R7 no mse push", int'(s_mpush), 0);
        wr_cmd(8'hD4); wr_dat(8'h3C);
        chk("R7 mse push", int'(s_mpush), 1);
        chk("R7 mse byte", int'(s_mtx), 'h3C);
        chk("R7 no kbd push", int'(s_kpush), 0);
        wr_dat(8'h41);
        chk("R10 pending cleared kbd", int'(s_kpush), 1);
        chk("R10 pending cleared mse", int'(s_mpush), 0);

        // R4 / R5 refill and priority
        wr_cmd(8'hD2); wr_dat(8'h11);
        kbd_avail = 1'b1; kbd_rx_byte = 8'h22;
        mse_avail = 1'b1; mse_rx_byte = 8'h33;
        idle();
        chk("R5 no kbd pull while full", int'(s_kpull), 0);
        chk("R5 no mse pull while full", int'(s_mpull), 0);
        rd_dat("R4 old byte", 'h11);
        chk("R4 kbd pulled", int'(s_kpull), 1);
        chk("R4 kbd first", int'(s_mpull), 0);
        chk("R3 refill kbd irq", int'(s_irqk), 1);
        kbd_avail = 1'b0;
        rd_stat("R4 refilled status", 'h15);
        rd_dat("R4 kbd byte", 'h22);
        chk("R4 mse pulled", int'(s_mpull), 1);
        chk("R3 refill mse irq", int'(s_irqm), 1);
        mse_avail = 1'b0;
        rd_stat("R4 mse status", 'h35);
        rd_dat("R4 mse byte", 'h33);
        rd_stat("R4 empty", 'h14);

        // R11 disable / enable bits
        wr_cmd(8'hA7); wr_cmd(8'h20); rd_dat("R11 mse off", 'h67);
        wr_cmd(8'hAD); wr_cmd(8'h20); rd_dat("R11 kbd off", 'h77);
        wr_cmd(8'hA8); wr_cmd(8'h20); rd_dat("R11 mse on", 'h57);
        wr_cmd(8'hAE); wr_cmd(8'h20); rd_dat("R11 kbd on", 'h47);

        // R12 output port data
        wr_cmd(8'hD1); wr_dat(8'h00);
        chk("R12 oport bit0 low", int'(s_err), 1);
        wr_cmd(8'hD1); wr_dat(8'h01);
        chk("R12 oport bit0 high", int'(s_err), 0);

        // R12 sweep of command codes
        for (int c = 0; c < 256; c++) begin
            if (c == 'h20 || c == 'h60 || c == 'hD1 || c == 'hD2 ||
                c == 'hD3 || c == 'hD4)
                continue;
            wr_cmd(8'(c));
            chk($sformatf("R12 code 0x%02h", c), int'(s_err), int'(exp_unsup(c)));
        end
        rd_stat("R6 after sweep", 'h1C);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule